// File: doc/BRIEF.md
# Frame Schedule List Walker

This block walks a host controller's periodic transfer schedule once per 1 ms frame. On each frame tick it moves the frame counter forward and reads one entry of a 1024-entry frame list held in memory. From that entry it follows a chain of link pointers through queue heads (two words) and transfer descriptors (four words). Each descriptor it reaches is handed to an external descriptor-processing unit. The walker then writes back the descriptor's control word when the unit changed it, and on success advances the queue's element pointer.

A link pointer carries its flags in the low nibble:
- bit 0 ends the chain;
- bit 1 marks a queue head (clear means a descriptor);
- bit 2 asks the walker to stay in the same queue after a success (depth-first).

The walk stops on a terminate bit, on an abort result, or when its step budget runs out. Only one transfer may be outstanding, and it is remembered by its queue-head address. While that transfer is open, descriptors in other queues are skipped. Interrupt causes gathered during a walk are posted at the start of the following frame.

Memory is reached through one word-addressed request port with a valid/ready handshake. Read data is taken in the cycle the handshake completes.

Top module: `frame_walker`

## Requirements
- R1: A frame tick that arrives while `run` is low sets `halted` and leaves `frame_num` unchanged. It makes no memory access and raises no `walk_done`.
- R2: A frame tick that arrives while `run` is high clears `halted` and advances `frame_num` by one, modulo 2048. The first memory access of that walk is a read at `list_base + ((frame_num & 0x3FF) << 2)`, using the new frame number.
- R3: In a link pointer, bit 0 = 1 ends the walk, bit 1 = 1 selects a queue head and bit 1 = 0 selects a descriptor. The pointed address is the link with bits 3:0 cleared.
- R4: A queue head is read as its horizontal link at its address and its element link at address + 4. An element link with bit 0 set sends the walk to the horizontal link. An element link with bit 1 set is followed as a nested queue head.
- R5: A descriptor is read as four words at address + 0, 4, 8 and 12, and the descriptor unit is then started once. The control word is written to address + 4 only when the unit returns a control value that differs from the one read.
- R6: Descriptor results are encoded 0 = success, 1 = not completed, 2 = left outstanding, 3 = abort. On success inside a queue, the descriptor's link is written to the queue head's address + 4. The walk then re-evaluates the same queue when bit 2 of that link is set, and otherwise moves to the horizontal link.
- R7: A descriptor reached directly from a link outside any queue is processed once, and the walk then follows that descriptor's own link.
- R8: An abort result ends the walk at once. No later descriptor is started.
- R9: The walk has a budget of `BUDGET` steps (100 by default). One step is used for each link taken at the top level, and one for each descriptor started from a queue. The walk ends when the budget reaches zero, so a chain of top-level descriptors processes at most `BUDGET - 1` of them.
- R10: A result of 2 inside a queue records that queue head in `pend_qh` and sets `pend_valid`. While `pend_valid` is set, descriptors inside queues are skipped, and reaching the recorded queue head ends the walk. A walk that began with a transfer outstanding and never reached its queue head pulses `pend_cancel` and clears `pend_valid`.
- R11: Cause bits from the descriptor unit (bit 0 = completion interrupt, bit 1 = short packet) are ORed over a walk. At the next running tick they are ORed into `int_causes`, and `int_status` is set if any bit is set. `int_ack` clears both.
- R12: `walk_done` is a one-cycle pulse at the end of each walk. A frame tick that arrives during a walk is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle pulse every 1 ms |
| run | input | 1 | Run (1) or stop (0) |
| list_base | input | 32 | Frame list base address, 4 KiB aligned |
| int_ack | input | 1 | Clears posted interrupt causes and status |
| xfer_done | input | 1 | Outstanding transfer finished elsewhere |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request; read data valid |
| mem_rdata | input | 32 | Read data |
| td_start | output | 1 | Start pulse to descriptor unit |
| td_link | output | 32 | Descriptor word 0 |
| td_ctrl | output | 32 | Descriptor word 1 |
| td_token | output | 32 | Descriptor word 2 |
| td_buffer | output | 32 | Descriptor word 3 |
| td_done | input | 1 | Descriptor unit finished |
| td_result | input | 2 | Result code (see R6) |
| td_new_ctrl | input | 32 | Updated control word |
| td_cause | input | 2 | Interrupt cause bits (see R11) |
| frame_num | output | 11 | Current frame number |
| halted | output | 1 | Controller halted |
| int_status | output | 1 | Interrupt status bit |
| int_causes | output | 2 | Posted cause bits |
| pend_valid | output | 1 | A transfer is outstanding |
| pend_qh | output | 32 | Queue-head address of the outstanding transfer |
| pend_cancel | output | 1 | One-cycle pulse when the outstanding transfer is dropped |
| walk_done | output | 1 | One-cycle pulse when a walk ends |

## Verification
The walker is tried with the following schedule shapes, each separating a different decision of the traversal:
- An empty frame entry.
- A chain of top-level descriptors, where the ctrl write-back happens only on change.
- A queue whose successful descriptor has its depth bit clear, and another where it is set. These tell breadth-first from depth-first, and the element-link write-back values show which was taken.
- Nested and empty queues.
- An abort placed mid-chain.
- An over-long chain that only the budget can stop.
- A three-frame sequence for the outstanding transfer: it is started, then met again, then missed, and only the last must cancel.
- Ticks with `run` low, ticks during a walk, and 2048 running frames, which together cover the halt path, the ignored tick, the frame-list index mask and the counter wrap.

// File: rtl/walker_pkg.sv
package walker_pkg;
  typedef enum logic [1:0] {
    RES_OK    = 2'd0,
    RES_MISS  = 2'd1,
    RES_ASYNC = 2'd2,
    RES_ABORT = 2'd3
  } td_res_e;

  typedef enum logic [3:0] {
    S_IDLE, S_FL, S_STEP, S_QH0, S_QH1, S_QEVAL,
    S_TD, S_CALL, S_CWB, S_POST, S_EWB, S_END
  } walk_st_e;

  localparam int LNK_TERM  = 0;
  localparam int LNK_QH    = 1;
  localparam int LNK_DEPTH = 2;
endpackage

// File: rtl/walk_irq.sv
module walk_irq #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          merge,
  input  logic          mask_load,
  input  logic [CW-1:0] mask_in,
  input  logic          int_ack,
  output logic [CW-1:0] causes,
  output logic          int_status
);
  logic [CW-1:0] held_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_mask  <= '0;
      causes     <= '0;
      int_status <= 1'b0;
    end else begin
      if (int_ack) begin
        causes     <= '0;
        int_status <= 1'b0;
      end
      if (merge) begin
        causes <= (int_ack ? '0 : causes) | held_mask;
        if (|held_mask) int_status <= 1'b1;
      end
      if (mask_load) held_mask <= mask_in;
    end
  end

  // R11: status can only rise at a frame-start merge
  a_r11_status_at_merge: assert property (@(posedge clk) disable iff (rst)
    $rose(int_status) |-> $past(merge));
endmodule

// File: rtl/walk_pend.sv
module walk_pend #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set,
  input  logic [AW-1:0] set_addr,
  input  logic          cancel,
  input  logic          complete,
  output logic          valid,
  output logic [AW-1:0] qh
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      qh    <= '0;
    end else if (set) begin
      valid <= 1'b1;
      qh    <= set_addr;
    end else if (cancel || complete) begin
      valid <= 1'b0;
    end
  end

  // R10: a second transfer is never opened while one is outstanding
  a_r10_single_pending: assert property (@(posedge clk) disable iff (rst)
    set |-> !valid);
  // R10: cancel only drops a transfer that exists
  a_r10_cancel_clears: assert property (@(posedge clk) disable iff (rst)
    (cancel && !set) |=> !valid);
endmodule

// File: rtl/walk_fsm.sv
module walk_fsm
  import walker_pkg::*;
#(
  parameter int BUDGET = 100,
  parameter int FN_W   = 11,
  parameter int FL_W   = 10,
  parameter int CW     = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frame_tick,
  input  logic            run,
  input  logic [31:0]     list_base,
  output logic            mem_valid,
  output logic            mem_we,
  output logic [31:0]     mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic            mem_ready,
  input  logic [31:0]     mem_rdata,
  output logic            td_start,
  output logic [31:0]     td_link,
  output logic [31:0]     td_ctrl,
  output logic [31:0]     td_token,
  output logic [31:0]     td_buffer,
  input  logic            td_done,
  input  logic [1:0]      td_result,
  input  logic [31:0]     td_new_ctrl,
  input  logic [CW-1:0]   td_cause,
  input  logic            pend_valid,
  input  logic [31:0]     pend_qh,
  output logic            pend_set,
  output logic [31:0]     pend_set_addr,
  output logic            pend_cancel,
  output logic [FN_W-1:0] frame_num,
  output logic            halted,
  output logic            merge,
  output logic            mask_load,
  output logic [CW-1:0]   walk_mask,
  output logic            walk_done
);
  localparam int BW = $clog2(BUDGET + 1);
  localparam logic [BW-1:0] BUDGET_INIT = BW'(BUDGET);

  walk_st_e       st;
  logic [31:0]    link, qh_addr, qh_hlink, qh_elink, td_addr;
  logic [BW-1:0]  budget;
  logic [1:0]     word_idx;
  logic           from_qh, old_pend, saw_pend;
  td_res_e        res;

  logic [FN_W-1:0] fn_next;
  logic [31:0]     fl_addr, link_addr, elink_addr;
  logic            hs;

  assign fn_next    = frame_num + 1'b1;
  assign fl_addr    = list_base + {{(32-FL_W-2){1'b0}}, fn_next[FL_W-1:0], 2'b00};
  assign link_addr  = {link[31:4], 4'h0};
  assign elink_addr = {qh_elink[31:4], 4'h0};
  assign hs         = mem_valid && mem_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      mem_valid <= 1'b0; mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
      td_start <= 1'b0; td_link <= '0; td_ctrl <= '0; td_token <= '0; td_buffer <= '0;
      pend_set <= 1'b0; pend_set_addr <= '0; pend_cancel <= 1'b0;
      frame_num <= '0; halted <= 1'b0; merge <= 1'b0; mask_load <= 1'b0;
      walk_mask <= '0; walk_done <= 1'b0;
      link <= '0; qh_addr <= '0; qh_hlink <= '0; qh_elink <= '0; td_addr <= '0;
      budget <= '0; word_idx <= '0; from_qh <= 1'b0; old_pend <= 1'b0;
      saw_pend <= 1'b0; res <= RES_OK;
    end else begin
      td_start    <= 1'b0;
      merge       <= 1'b0;
      mask_load   <= 1'b0;
      pend_set    <= 1'b0;
      pend_cancel <= 1'b0;
      walk_done   <= 1'b0;
      if (hs) mem_valid <= 1'b0;

      case (st)
        S_IDLE: if (frame_tick) begin
          if (!run) begin
            halted <= 1'b1;
          end else begin
            halted    <= 1'b0;
            frame_num <= fn_next;
            merge     <= 1'b1;
            budget    <= BUDGET_INIT;
            old_pend  <= pend_valid;
            saw_pend  <= 1'b0;
            walk_mask <= '0;
            mem_valid <= 1'b1; mem_we <= 1'b0; mem_addr <= fl_addr;
            st <= S_FL;
          end
        end

        S_FL: if (hs) begin
          link <= mem_rdata;
          st   <= S_STEP;
        end

        S_STEP: begin
          if (link[LNK_TERM]) begin
            st <= S_END;
          end else if (budget <= 1) begin
            budget <= '0;
            st <= S_END;
          end else begin
            budget <= budget - 1'b1;
            if (link[LNK_QH]) begin
              if (pend_valid && link_addr == pend_qh) begin
                saw_pend <= 1'b1;
                st <= S_END;
              end else begin
                qh_addr   <= link_addr;
                mem_valid <= 1'b1; mem_we <= 1'b0; mem_addr <= link_addr;
                st <= S_QH0;
              end
            end else begin
              td_addr   <= link_addr;
              from_qh   <= 1'b0;
              word_idx  <= '0;
              mem_valid <= 1'b1; mem_we <= 1'b0; mem_addr <= link_addr;
              st <= S_TD;
            end
          end
        end

        S_QH0: if (hs) begin
          qh_hlink  <= mem_rdata;
          mem_valid <= 1'b1; mem_we <= 1'b0; mem_addr <= qh_addr + 32'd4;
          st <= S_QH1;
        end

        S_QH1: if (hs) begin
          qh_elink <= mem_rdata;
          st <= S_QEVAL;
        end

        S_QEVAL: begin
          if (qh_elink[LNK_TERM]) begin
            link <= qh_hlink;
            st <= S_STEP;
          end else if (qh_elink[LNK_QH]) begin
            link <= qh_elink;
            st <= S_STEP;
          end else if (pend_valid) begin
            link <= qh_hlink;
            st <= S_STEP;
          end else if (budget <= 1) begin
            budget <= '0;
            st <= S_END;
          end else begin
            budget    <= budget - 1'b1;
            td_addr   <= elink_addr;
            from_qh   <= 1'b1;
            word_idx  <= '0;
            mem_valid <= 1'b1; mem_we <= 1'b0; mem_addr <= elink_addr;
            st <= S_TD;
          end
        end

        S_TD: if (hs) begin
          case (word_idx)
            2'd0:    td_link   <= mem_rdata;
            2'd1:    td_ctrl   <= mem_rdata;
            2'd2:    td_token  <= mem_rdata;
            default: td_buffer <= mem_rdata;
          endcase
          if (word_idx == 2'd3) begin
            td_start <= 1'b1;
            st <= S_CALL;
          end else begin
            word_idx  <= word_idx + 1'b1;
            mem_valid <= 1'b1; mem_we <= 1'b0;
            mem_addr  <= td_addr + {28'd0, word_idx + 2'd1, 2'b00};
          end
        end

        S_CALL: if (td_done) begin
          walk_mask <= walk_mask | td_cause;
          res <= td_res_e'(td_result);
          if (td_new_ctrl != td_ctrl) begin
            mem_valid <= 1'b1; mem_we <= 1'b1;
            mem_addr  <= td_addr + 32'd4; mem_wdata <= td_new_ctrl;
            st <= S_CWB;
          end else begin
            st <= S_POST;
          end
        end

        S_CWB: if (hs) st <= S_POST;

        S_POST: begin
          if (res == RES_ABORT) begin
            st <= S_END;
          end else if (!from_qh) begin
            link <= td_link;
            st <= S_STEP;
          end else if (res == RES_ASYNC) begin
            pend_set      <= 1'b1;
            pend_set_addr <= qh_addr;
            link <= qh_hlink;
            st <= S_STEP;
          end else if (res == RES_OK) begin
            qh_elink  <= td_link;
            mem_valid <= 1'b1; mem_we <= 1'b1;
            mem_addr  <= qh_addr + 32'd4; mem_wdata <= td_link;
            st <= S_EWB;
          end else begin
            link <= qh_hlink;
            st <= S_STEP;
          end
        end

        S_EWB: if (hs) begin
          if (qh_elink[LNK_DEPTH]) begin
            st <= S_QEVAL;
          end else begin
            link <= qh_hlink;
            st <= S_STEP;
          end
        end

        S_END: begin
          mask_load <= 1'b1;
          walk_done <= 1'b1;
          if (old_pend && !saw_pend && pend_valid) pend_cancel <= 1'b1;
          st <= S_IDLE;
        end

        default: st <= S_IDLE;
      endcase
    end
  end

  // R2: a running tick moves the frame counter by exactly one
  a_r2_frame_step: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && frame_tick && run) |=> frame_num == $past(frame_num) + 1'b1);
  // R1: a stopped tick leaves the counter alone and marks halt
  a_r1_halt_on_stop: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && frame_tick && !run) |=> halted && $stable(frame_num));
  // R5: a request is held until accepted
  a_r5_req_held: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_addr) && $stable(mem_we));
  // R9: the step budget never exceeds its start value
  a_r9_budget_bound: assert property (@(posedge clk) disable iff (rst)
    budget <= BUDGET_INIT);
  // R12: the end-of-walk pulse lasts one cycle
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
    walk_done |=> !walk_done);
  // R8: no descriptor starts once an abort has been taken
  a_r8_abort_stops: assert property (@(posedge clk) disable iff (rst)
    (st == S_POST && res == RES_ABORT) |=> st == S_END);
endmodule

// File: rtl/frame_walker.sv
module frame_walker #(
  parameter int BUDGET = 100,
  parameter int FN_W   = 11,
  parameter int FL_W   = 10,
  parameter int CW     = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frame_tick,
  input  logic            run,
  input  logic [31:0]     list_base,
  input  logic            int_ack,
  input  logic            xfer_done,
  output logic            mem_valid,
  output logic            mem_we,
  output logic [31:0]     mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic            mem_ready,
  input  logic [31:0]     mem_rdata,
  output logic            td_start,
  output logic [31:0]     td_link,
  output logic [31:0]     td_ctrl,
  output logic [31:0]     td_token,
  output logic [31:0]     td_buffer,
  input  logic            td_done,
  input  logic [1:0]      td_result,
  input  logic [31:0]     td_new_ctrl,
  input  logic [CW-1:0]   td_cause,
  output logic [FN_W-1:0] frame_num,
  output logic            halted,
  output logic            int_status,
  output logic [CW-1:0]   int_causes,
  output logic            pend_valid,
  output logic [31:0]     pend_qh,
  output logic            pend_cancel,
  output logic            walk_done
);
  logic          merge, mask_load, pend_set;
  logic [CW-1:0] walk_mask;
  logic [31:0]   pend_set_addr;

  walk_fsm #(.BUDGET(BUDGET), .FN_W(FN_W), .FL_W(FL_W), .CW(CW)) u_fsm (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .run(run), .list_base(list_base),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .td_start(td_start), .td_link(td_link), .td_ctrl(td_ctrl), .td_token(td_token),
    .td_buffer(td_buffer), .td_done(td_done), .td_result(td_result),
    .td_new_ctrl(td_new_ctrl), .td_cause(td_cause),
    .pend_valid(pend_valid), .pend_qh(pend_qh), .pend_set(pend_set),
    .pend_set_addr(pend_set_addr), .pend_cancel(pend_cancel),
    .frame_num(frame_num), .halted(halted), .merge(merge), .mask_load(mask_load),
    .walk_mask(walk_mask), .walk_done(walk_done)
  );

  walk_irq #(.CW(CW)) u_irq (
    .clk(clk), .rst(rst), .merge(merge), .mask_load(mask_load), .mask_in(walk_mask),
    .int_ack(int_ack), .causes(int_causes), .int_status(int_status)
  );

  walk_pend #(.AW(32)) u_pend (
    .clk(clk), .rst(rst), .set(pend_set), .set_addr(pend_set_addr),
    .cancel(pend_cancel), .complete(xfer_done), .valid(pend_valid), .qh(pend_qh)
  );
endmodule

// File: tb/frame_walker_test.sv
`timescale 1ns/1ps
module frame_walker_test;
  localparam logic [31:0] BASE = 32'h0000_3000;

  logic clk = 1'b0, rst = 1'b1;
  logic frame_tick = 1'b0, run = 1'b0, int_ack = 1'b0, xfer_done = 1'b0;
  logic mem_valid, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic td_start, td_done = 1'b0;
  logic [31:0] td_link, td_ctrl, td_token, td_buffer, td_new_ctrl = '0;
  logic [1:0] td_result = '0, td_cause = '0;
  logic [10:0] frame_num;
  logic halted, int_status, pend_valid, pend_cancel, walk_done;
  logic [1:0] int_causes;
  logic [31:0] pend_qh;

  always #2.5 clk = ~clk;

  frame_walker uut (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .run(run), .list_base(BASE),
    .int_ack(int_ack), .xfer_done(xfer_done),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .td_start(td_start), .td_link(td_link), .td_ctrl(td_ctrl), .td_token(td_token),
    .td_buffer(td_buffer), .td_done(td_done), .td_result(td_result),
    .td_new_ctrl(td_new_ctrl), .td_cause(td_cause),
    .frame_num(frame_num), .halted(halted), .int_status(int_status),
    .int_causes(int_causes), .pend_valid(pend_valid), .pend_qh(pend_qh),
    .pend_cancel(pend_cancel), .walk_done(walk_done)
  );

  // memory model: 4096 words, ready every other cycle
  logic [31:0] mem [0:4095];
  logic        rdy_tog = 1'b0;
  assign mem_ready = rdy_tog;
  assign mem_rdata = mem[mem_addr[13:2]];

  int acn = 0, wn = 0, tdn = 0, cancels = 0;
  logic [31:0] alog [0:255];
  logic [31:0] wlog_a [0:255];
  logic [31:0] wlog_d [0:255];
  logic [31:0] tdlog [0:255];

  always @(posedge clk) begin
    rdy_tog <= ~rdy_tog;
    if (mem_valid && mem_ready) begin
      alog[acn[7:0]] <= mem_addr;
      acn <= acn + 1;
      if (mem_we) begin
        mem[mem_addr[13:2]] <= mem_wdata;
        wlog_a[wn[7:0]] <= mem_addr;
        wlog_d[wn[7:0]] <= mem_wdata;
        wn <= wn + 1;
      end
    end
    if (pend_cancel) cancels <= cancels + 1;
  end

  // descriptor unit model: token[1:0]=result, [3:2]=cause, [4]=bump ctrl
  int dcnt = 0;
  logic [31:0] dtok = '0, dctrl = '0;
  always @(posedge clk) begin
    td_done <= 1'b0;
    if (td_start) begin
      dcnt <= 2; dtok <= td_token; dctrl <= td_ctrl;
      tdlog[tdn[7:0]] <= td_buffer;
      tdn <= tdn + 1;
    end else if (dcnt == 1) begin
      dcnt <= 0;
      td_done <= 1'b1;
      td_result <= dtok[1:0];
      td_cause <= dtok[3:2];
      td_new_ctrl <= dtok[4] ? dctrl + 32'd1 : dctrl;
    end else if (dcnt != 0) begin
      dcnt <= dcnt - 1;
    end
  end

  int checks = 0, errors = 0;
  int exp_fn = 0;
  bit finished = 1'b0;
  int a0, w0, t0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] tok(input int res, input int cause, input int chg);
    return {27'd0, chg[0], cause[1:0], res[1:0]};
  endfunction

  task automatic put_td(input logic [31:0] a, input logic [31:0] lnk, input logic [31:0] tk, input logic [31:0] id);
    mem[a[13:2]]     = lnk;
    mem[a[13:2] + 1] = 32'h0080_0000;
    mem[a[13:2] + 2] = tk;
    mem[a[13:2] + 3] = id;
  endtask

  task automatic put_qh(input logic [31:0] a, input logic [31:0] h, input logic [31:0] e);
    mem[a[13:2]]     = h;
    mem[a[13:2] + 1] = e;
  endtask

  function automatic int ent_idx(input int fn);
    return (BASE[13:2]) + (fn & 32'h3FF);
  endfunction

  // one running frame with a given frame-list entry; entry restored afterwards
  task automatic do_frame(input logic [31:0] entry);
    int nf = (exp_fn + 1) & 32'h7FF;
    mem[ent_idx(nf)] = entry;
    a0 = acn; w0 = wn; t0 = tdn;
    @(negedge clk) frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
    while (!walk_done) @(negedge clk);
    exp_fn = nf;
    @(negedge clk);
    chk(!walk_done, "R12 done width", {31'd0, walk_done}, 32'd0);
    mem[ent_idx(nf)] = 32'h1;
  endtask

  task automatic t_reset;
    chk(frame_num == 11'd0 && !halted && !int_status && !pend_valid && !mem_valid,
        "reset state", {frame_num, 5'd0, halted, int_status, pend_valid, mem_valid}, 32'd0);
  endtask

  task automatic t_empty;  // R2 R3
    do_frame(32'h1);
    chk(frame_num == 11'd1, "R2 frame step", 32'(frame_num), 32'd1);
    chk(acn - a0 == 1, "R3 terminate single access", acn - a0, 1);
    chk(alog[a0[7:0]] == BASE + 32'd4, "R2 entry address", alog[a0[7:0]], BASE + 32'd4);
    chk(!halted, "R2 halted clear", {31'd0, halted}, 0);
  endtask

  task automatic t_direct;  // R7 R5 R3
    put_td(32'h100, 32'h110, tok(1, 0, 0), 32'hA1);
    put_td(32'h110, 32'h1,   tok(0, 0, 1), 32'hB1);
    do_frame(32'h108);
    chk(tdn - t0 == 2 && tdlog[t0[7:0]] == 32'hA1 && tdlog[t0[7:0]+1] == 32'hB1,
        "R7 direct chain", tdn - t0, 2);
    chk(acn - a0 == 10, "R5 four-word reads", acn - a0, 10);
    chk(wn - w0 == 1 && wlog_a[w0[7:0]] == 32'h114 && wlog_d[w0[7:0]] == 32'h0080_0001,
        "R5 ctrl write only on change", wlog_a[w0[7:0]], 32'h114);
  endtask

  task automatic t_breadth;  // R6
    put_qh(32'h200, 32'h1, 32'h300);
    put_td(32'h300, 32'h310, tok(0, 0, 0), 32'hC1);
    put_td(32'h310, 32'h1,   tok(0, 0, 0), 32'hC2);
    do_frame(32'h202);
    chk(tdn - t0 == 1, "R6 breadth-first one td", tdn - t0, 1);
    chk(wn - w0 == 1 && wlog_a[w0[7:0]] == 32'h204 && wlog_d[w0[7:0]] == 32'h310,
        "R6 element link write", wlog_d[w0[7:0]], 32'h310);
  endtask

  task automatic t_depth;  // R6
    put_qh(32'h400, 32'h1, 32'h500);
    put_td(32'h500, 32'h514, tok(0, 0, 0), 32'hD1);
    put_td(32'h510, 32'h5,   tok(0, 0, 0), 32'hD2);
    do_frame(32'h402);
    chk(tdn - t0 == 2 && tdlog[t0[7:0]+1] == 32'hD2, "R6 depth-first two tds", tdn - t0, 2);
    chk(wn - w0 == 2 && mem[32'h404 >> 2] == 32'h5, "R6 final element link", mem[32'h404 >> 2], 32'h5);
  endtask

  task automatic t_nested;  // R4
    put_qh(32'h600, 32'h1, 32'h702);
    put_qh(32'h700, 32'h1, 32'h800);
    put_td(32'h800, 32'h1, tok(1, 0, 0), 32'hE1);
    do_frame(32'h602);
    chk(tdn - t0 == 1 && tdlog[t0[7:0]] == 32'hE1, "R4 nested queue followed", tdn - t0, 1);
    chk(acn - a0 == 9 && alog[a0[7:0]+2] == 32'h604, "R4 queue word addresses", acn - a0, 9);
    put_qh(32'h640, 32'h900, 32'h1);
    put_td(32'h900, 32'h1, tok(1, 0, 0), 32'hF1);
    do_frame(32'h642);
    chk(tdn - t0 == 1 && tdlog[t0[7:0]] == 32'hF1, "R4 empty queue to horizontal", tdn - t0, 1);
  endtask

  task automatic t_abort;  // R8
    put_td(32'hA00, 32'hA10, tok(3, 0, 0), 32'h61);
    put_td(32'hA10, 32'h1,   tok(1, 0, 0), 32'h62);
    do_frame(32'hA00);
    chk(tdn - t0 == 1, "R8 abort ends walk", tdn - t0, 1);
    chk(acn - a0 == 5, "R8 no access after abort", acn - a0, 5);
  endtask

  task automatic t_pending;  // R10
    put_qh(32'hB00, 32'hB22, 32'hC00);
    put_qh(32'hB20, 32'h1,   32'hC10);
    put_td(32'hC00, 32'h1, tok(2, 0, 0), 32'h71);
    put_td(32'hC10, 32'h1, tok(1, 0, 0), 32'h72);
    do_frame(32'hB02);
    chk(tdn - t0 == 1 && pend_valid && pend_qh == 32'hB00, "R10 pending recorded, other queue skipped",
        pend_qh, 32'hB00);
    do_frame(32'hB02);
    chk(tdn - t0 == 0 && acn - a0 == 1 && pend_valid && cancels == 0,
        "R10 reaching pending queue ends walk", acn - a0, 1);
    do_frame(32'hB22);
    chk(tdn - t0 == 0 && cancels == 1 && !pend_valid, "R10 missed pending cancelled", cancels, 1);
  endtask

  task automatic t_irq;  // R11
    put_td(32'hD00, 32'hD10, tok(1, 1, 0), 32'h81);
    put_td(32'hD10, 32'h1,   tok(1, 2, 0), 32'h82);
    do_frame(32'hD00);
    chk(!int_status && int_causes == 2'b00, "R11 not posted before next frame", 32'(int_causes), 0);
    do_frame(32'h1);
    chk(int_status && int_causes == 2'b11, "R11 posted at next frame", 32'(int_causes), 3);
    @(negedge clk) int_ack = 1'b1;
    @(negedge clk) int_ack = 1'b0;
    chk(!int_status && int_causes == 2'b00, "R11 ack clears", {31'd0, int_status}, 0);
    do_frame(32'h1);
    chk(!int_status, "R11 no causes no status", {31'd0, int_status}, 0);
  endtask

  task automatic t_budget;  // R9 R12
    for (int i = 0; i < 120; i++)
      put_td(32'h1000 + 32'(i) * 16, (i == 119) ? 32'h1 : 32'h1000 + 32'(i + 1) * 16,
             tok(1, 0, 0), 32'(i));
    mem[ent_idx(exp_fn + 1)] = 32'h1000;
    t0 = tdn;
    @(negedge clk) frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
    repeat (100) @(negedge clk);
    frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
    while (!walk_done) @(negedge clk);
    exp_fn = (exp_fn + 1) & 32'h7FF;
    mem[ent_idx(exp_fn)] = 32'h1;
    chk(tdn - t0 == 99, "R9 budget stops walk", tdn - t0, 99);
    chk(32'(frame_num) == exp_fn, "R12 tick during walk ignored", 32'(frame_num), exp_fn);
  endtask

  task automatic t_halt;  // R1
    int a1;
    run = 1'b0;
    a1 = acn;
    @(negedge clk) frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (walk_done) chk(1'b0, "R1 no done when stopped", 1, 0);
    end
    chk(halted && 32'(frame_num) == exp_fn && acn == a1, "R1 halt on stopped tick",
        32'(frame_num), exp_fn);
    run = 1'b1;
    do_frame(32'h1);
    chk(!halted, "R1 halt cleared on running tick", {31'd0, halted}, 0);
  endtask

  task automatic t_wrap;  // R2
    while (exp_fn != 32'h404) do_frame(32'h1);
    do_frame(32'h1);
    chk(alog[a0[7:0]] == BASE + 32'h14, "R2 frame-list index masked", alog[a0[7:0]], BASE + 32'h14);
    while (exp_fn != 32'h7FF) do_frame(32'h1);
    do_frame(32'h1);
    chk(frame_num == 11'd0, "R2 wrap to zero", 32'(frame_num), 0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    for (int i = 0; i < 1024; i++) mem[BASE[13:2] + i] = 32'h1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    run = 1'b1;
    t_empty();
    t_direct();
    t_breadth();
    t_depth();
    t_nested();
    t_abort();
    t_pending();
    t_irq();
    t_budget();
    t_halt();
    t_wrap();
    finish_run();
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000 && !finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      finish_run();
    end
  end
endmodule